// File: doc/BRIEF.md
# Serial Input-Device Report Generator

This block produces the byte stream that a serial keyboard/mouse port hands to its host. Mouse movement events, already-translated key events and command bytes written by the host are turned into report bytes and kept in a circular byte queue. The host pops the queue one byte at a time and sees a flag whenever data is waiting.

A mouse event becomes a fixed five-byte packet. Key events become a single byte carrying the release flag in its top bit. The two lock keys (caps and num) are filtered so that only the first press and the second release of each lock cycle reach the host. Host command bytes are answered with identification or layout responses, and one command makes the next host byte an LED setting that is swallowed. Each event source has a one-entry holding slot with a ready flag. A fixed-priority stage feeds one whole packet at a time into the queue, one byte per cycle.

Top module: `sio_report_gen`

## Requirements
- R1: The queue keeps bytes in arrival order and holds up to DEPTH (default 256) bytes. A byte produced while the queue already holds DEPTH bytes is discarded, and the earlier contents are kept.
- R2: `data_o` always shows the oldest byte and `avail_o` is high while the queue is not empty. When the queue is empty, `data_o` reads 0x00 and a pop request has no effect. `avail_o` falls after the pop of the last byte.
- R3: A mouse event yields five bytes. The first is a header: 0x87 with bit 2 cleared if `mouse_btn_i[2]` (left) is pressed, bit 1 cleared if `mouse_btn_i[1]` (middle) is pressed and bit 0 cleared if `mouse_btn_i[0]` (right) is pressed. The last two bytes are 0x00.
- R4: The second mouse byte is the X delta and the third is the negated Y delta. Each is saturated to -127..+127 and sent in two's complement, so an excess negative value gives 0x81 and an excess positive value gives 0x7F.
- R5: Host command 0x01 empties the queue and then queues 0xFF, 0x04, 0x7F.
- R6: Host commands 0x07 and 0x0F each empty the queue and then queue 0xFE, 0x21.
- R7: After host command 0x0E, the next host byte is taken as LED data and has no effect, whatever its value.
- R8: Any other host byte leaves the queue unchanged.
- R9: A key event with a normal keycode queues one byte: the keycode in bits 6:0, and bit 7 set for a release or clear for a press.
- R10: The caps keycode (CAPS_CODE, default 119) and the num keycode (NUM_CODE, default 98) each keep a 2-bit state. A press toggles bit 0 and is dropped if the state then equals 2. A release toggles bit 1 and is dropped if the state then equals 3.
- R11: After reset the queue is empty (`avail_o` low, `data_o` 0x00), all ready flags are high, both lock states are 0 and no LED byte is pending.
- R12: Events that wait in their slots are packed one whole packet at a time, in the priority order command, then mouse, then key. A slot's ready flag stays low from the cycle after it is loaded until its packet is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mouse_valid_i | input | 1 | Mouse event strobe |
| mouse_btn_i | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| mouse_dx_i | input | DELTA_W | Signed X movement |
| mouse_dy_i | input | DELTA_W | Signed Y movement |
| mouse_rdy_o | output | 1 | Mouse slot free |
| key_valid_i | input | 1 | Key event strobe |
| key_code_i | input | 7 | Translated keycode |
| key_release_i | input | 1 | 1 = release, 0 = press |
| key_rdy_o | output | 1 | Key slot free |
| cmd_valid_i | input | 1 | Host byte strobe |
| cmd_data_i | input | 8 | Host byte |
| cmd_rdy_o | output | 1 | Command slot free |
| pop_i | input | 1 | Remove the oldest byte |
| data_o | output | 8 | Oldest byte, 0x00 when empty |
| avail_o | output | 1 | Queue not empty |

## Verification
The properties assume that each strobe is raised only while its ready flag is high, so a waiting event is never overwritten, and that DELTA_W is at least 8. The stimulus waits for the ready flag at a falling edge before it raises any strobe, and it drives deltas only inside the signed DELTA_W range. The three-source collision test raises all strobes in the same cycle, so it lands only on slots that are empty.

// File: rtl/sio_rg_pkg.sv
package sio_rg_pkg;
  localparam int PKT_MAX = 5;
  localparam int LEN_W   = 3;

  typedef struct packed {
    logic                          flush;
    logic [LEN_W-1:0]              len;
    logic [PKT_MAX-1:0][7:0]       bytes;
  } pkt_t;

  localparam logic [7:0] MS_HDR_BASE = 8'h87;
  localparam logic [7:0] CMD_RESET   = 8'h01;
  localparam logic [7:0] CMD_LAYOUT0 = 8'h07;
  localparam logic [7:0] CMD_LED     = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT1 = 8'h0F;
endpackage

// File: rtl/sio_rg_fifo.sv
module sio_rg_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [AW:0]   cnt_o
);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q < FULL_CNT);
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= push_data_i;
  end

  assign head_o = (cnt_q != '0) ? mem_q[rd_q] : '0;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sio_rg_mouse.sv
module sio_rg_mouse
  import sio_rg_pkg::*;
#(
  parameter int DELTA_W = 10
) (
  input  logic [2:0]         btn_i,
  input  logic [DELTA_W-1:0] dx_i,
  input  logic [DELTA_W-1:0] dy_i,
  output pkt_t               pkt_o
);
  localparam int EW = DELTA_W + 1;
  localparam logic signed [EW-1:0] POS_LIM = EW'(127);
  localparam logic signed [EW-1:0] NEG_LIM = -EW'(127);

  function automatic logic [7:0] sat8(input logic signed [EW-1:0] v);
    if (v > POS_LIM)      return 8'h7F;
    else if (v < NEG_LIM) return 8'h81;
    else                  return v[7:0];
  endfunction

  logic signed [EW-1:0] dx_ext, dy_neg;

  assign dx_ext = $signed({dx_i[DELTA_W-1], dx_i});
  assign dy_neg = -$signed({dy_i[DELTA_W-1], dy_i});

  always_comb begin
    pkt_o          = '0;
    pkt_o.flush    = 1'b0;
    pkt_o.len      = LEN_W'(PKT_MAX);
    pkt_o.bytes[0] = MS_HDR_BASE & ~{5'b0, btn_i};
    pkt_o.bytes[1] = sat8(dx_ext);
    pkt_o.bytes[2] = sat8(dy_neg);
    pkt_o.bytes[3] = 8'h00;
    pkt_o.bytes[4] = 8'h00;
  end
endmodule

// File: rtl/sio_rg_kbd_cmd.sv
module sio_rg_kbd_cmd
  import sio_rg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic [7:0] cmd_i,
  output pkt_t       pkt_o
);
  logic led_q, led_d;

  always_comb begin
    pkt_o = '0;
    led_d = led_q;
    if (led_q) begin
      led_d = 1'b0;
    end else begin
      unique case (cmd_i)
        CMD_RESET: begin
          pkt_o.flush    = 1'b1;
          pkt_o.len      = LEN_W'(3);
          pkt_o.bytes[0] = 8'hFF;
          pkt_o.bytes[1] = 8'h04;
          pkt_o.bytes[2] = 8'h7F;
        end
        CMD_LAYOUT0, CMD_LAYOUT1: begin
          pkt_o.flush    = 1'b1;
          pkt_o.len      = LEN_W'(2);
          pkt_o.bytes[0] = 8'hFE;
          pkt_o.bytes[1] = 8'h21;
        end
        CMD_LED: led_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     led_q <= 1'b0;
    else if (take_i) led_q <= led_d;
  end
endmodule

// File: rtl/sio_rg_keys.sv
module sio_rg_keys
  import sio_rg_pkg::*;
#(
  parameter logic [6:0] CAPS_CODE = 7'd119,
  parameter logic [6:0] NUM_CODE  = 7'd98
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic [6:0] code_i,
  input  logic       release_i,
  output pkt_t       pkt_o
);
  localparam int NLOCK = 2;
  localparam logic [NLOCK-1:0][6:0] LOCK_CODES = {NUM_CODE, CAPS_CODE};

  logic [NLOCK-1:0] drop;

  for (genvar i = 0; i < NLOCK; i++) begin : g_lock
    logic [1:0] st_q, st_d;
    logic       hit;
    assign hit  = (code_i == LOCK_CODES[i]);
    assign st_d = release_i ? (st_q ^ 2'b10) : (st_q ^ 2'b01);
    assign drop[i] = hit && (release_i ? (st_d == 2'd3) : (st_d == 2'd2));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             st_q <= '0;
      else if (take_i && hit)  st_q <= st_d;
    end
  end

  always_comb begin
    pkt_o          = '0;
    pkt_o.len      = (drop != '0) ? '0 : LEN_W'(1);
    pkt_o.bytes[0] = {release_i, code_i};
  end
endmodule

// File: rtl/sio_report_gen.sv
module sio_report_gen
  import sio_rg_pkg::*;
#(
  parameter int         DEPTH     = 256,
  parameter int         DELTA_W   = 10,
  parameter logic [6:0] CAPS_CODE = 7'd119,
  parameter logic [6:0] NUM_CODE  = 7'd98
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mouse_valid_i,
  input  logic [2:0]         mouse_btn_i,
  input  logic [DELTA_W-1:0] mouse_dx_i,
  input  logic [DELTA_W-1:0] mouse_dy_i,
  output logic               mouse_rdy_o,
  input  logic               key_valid_i,
  input  logic [6:0]         key_code_i,
  input  logic               key_release_i,
  output logic               key_rdy_o,
  input  logic               cmd_valid_i,
  input  logic [7:0]         cmd_data_i,
  output logic               cmd_rdy_o,
  input  logic               pop_i,
  output logic [7:0]         data_o,
  output logic               avail_o
);
  localparam int AW = $clog2(DEPTH);

  // holding slots
  logic               ms_full_q, key_full_q, cmd_full_q;
  logic [2:0]         ms_btn_q;
  logic [DELTA_W-1:0] ms_dx_q, ms_dy_q;
  logic [6:0]         key_code_q;
  logic               key_rel_q;
  logic [7:0]         cmd_q;

  // arbitration and sequencing
  logic [2:0]              grant;   // [2] cmd, [1] mouse, [0] key
  logic                    seq_busy;
  pkt_t                    ms_pkt, key_pkt, cmd_pkt, pkt_sel;
  logic [PKT_MAX-1:0][7:0] seq_bytes_q;
  logic [LEN_W-1:0]        seq_len_q, seq_idx_q;

  logic        q_push, q_flush;
  logic [7:0]  q_wdata;
  logic [AW:0] q_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_full_q  <= 1'b0;
      key_full_q <= 1'b0;
      cmd_full_q <= 1'b0;
      ms_btn_q   <= '0;
      ms_dx_q    <= '0;
      ms_dy_q    <= '0;
      key_code_q <= '0;
      key_rel_q  <= 1'b0;
      cmd_q      <= '0;
    end else begin
      if (mouse_valid_i && mouse_rdy_o) begin
        ms_full_q <= 1'b1;
        ms_btn_q  <= mouse_btn_i;
        ms_dx_q   <= mouse_dx_i;
        ms_dy_q   <= mouse_dy_i;
      end else if (grant[1]) begin
        ms_full_q <= 1'b0;
      end
      if (key_valid_i && key_rdy_o) begin
        key_full_q <= 1'b1;
        key_code_q <= key_code_i;
        key_rel_q  <= key_release_i;
      end else if (grant[0]) begin
        key_full_q <= 1'b0;
      end
      if (cmd_valid_i && cmd_rdy_o) begin
        cmd_full_q <= 1'b1;
        cmd_q      <= cmd_data_i;
      end else if (grant[2]) begin
        cmd_full_q <= 1'b0;
      end
    end
  end

  assign mouse_rdy_o = !ms_full_q;
  assign key_rdy_o   = !key_full_q;
  assign cmd_rdy_o   = !cmd_full_q;

  assign seq_busy = (seq_idx_q != seq_len_q);

  always_comb begin
    grant = '0;
    if (!seq_busy) begin
      if (cmd_full_q)      grant[2] = 1'b1;
      else if (ms_full_q)  grant[1] = 1'b1;
      else if (key_full_q) grant[0] = 1'b1;
    end
  end

  sio_rg_mouse #(.DELTA_W(DELTA_W)) u_mouse (
    .btn_i (ms_btn_q),
    .dx_i  (ms_dx_q),
    .dy_i  (ms_dy_q),
    .pkt_o (ms_pkt)
  );

  sio_rg_kbd_cmd u_kbd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (grant[2]),
    .cmd_i  (cmd_q),
    .pkt_o  (cmd_pkt)
  );

  sio_rg_keys #(.CAPS_CODE(CAPS_CODE), .NUM_CODE(NUM_CODE)) u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (grant[0]),
    .code_i    (key_code_q),
    .release_i (key_rel_q),
    .pkt_o     (key_pkt)
  );

  always_comb begin
    pkt_sel = '0;
    if (grant[2])      pkt_sel = cmd_pkt;
    else if (grant[1]) pkt_sel = ms_pkt;
    else if (grant[0]) pkt_sel = key_pkt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_bytes_q <= '0;
      seq_len_q   <= '0;
      seq_idx_q   <= '0;
    end else if (grant != '0) begin
      seq_bytes_q <= pkt_sel.bytes;
      seq_len_q   <= pkt_sel.len;
      seq_idx_q   <= '0;
    end else if (seq_busy) begin
      seq_idx_q   <= seq_idx_q + 1'b1;
    end
  end

  assign q_flush = (grant != '0) && pkt_sel.flush;
  assign q_push  = seq_busy;
  assign q_wdata = seq_bytes_q[seq_idx_q];

  sio_rg_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (q_flush),
    .push_i      (q_push),
    .push_data_i (q_wdata),
    .pop_i       (pop_i),
    .head_o      (data_o),
    .cnt_o       (q_cnt)
  );

  assign avail_o = (q_cnt != '0);
endmodule

// File: rtl/sio_rg_checks.sv
module sio_rg_checks #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pop_i,
  input logic        avail_o,
  input logic [7:0]  data_o,
  input logic [AW:0] q_cnt,
  input logic        q_push,
  input logic        q_flush,
  input logic        seq_busy,
  input logic [2:0]  grant
);
  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt <= (AW+1)'(DEPTH));

  assert_pop_dec_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && avail_o && !q_push && !q_flush) |=> (q_cnt == $past(q_cnt) - 1'b1));

  assert_empty_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_o |-> (data_o == 8'h00));

  assert_flush_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_flush |=> !avail_o);

  assert_no_interleave_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy |-> (grant == 3'b000));

  assert_one_grant_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
endmodule

bind sio_report_gen sio_rg_checks #(.DEPTH(DEPTH)) u_checks (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pop_i    (pop_i),
  .avail_o  (avail_o),
  .data_o   (data_o),
  .q_cnt    (q_cnt),
  .q_push   (q_push),
  .q_flush  (q_flush),
  .seq_busy (seq_busy),
  .grant    (grant)
);

// File: tb/sio_report_gen_test.sv
`timescale 1ns/1ps
module sio_report_gen_test;
  localparam int DEPTH   = 256;
  localparam int DELTA_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mouse_valid = 0, key_valid = 0, cmd_valid = 0, pop = 0;
  logic [2:0] mouse_btn = 0;
  logic [DELTA_W-1:0] mouse_dx = 0, mouse_dy = 0;
  logic [6:0] key_code = 0;
  logic key_rel = 0;
  logic [7:0] cmd_data = 0;
  logic mouse_rdy, key_rdy, cmd_rdy, avail;
  logic [7:0] data;

  always #2.5 clk = ~clk;

  sio_report_gen #(.DEPTH(DEPTH), .DELTA_W(DELTA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .mouse_valid_i(mouse_valid), .mouse_btn_i(mouse_btn),
    .mouse_dx_i(mouse_dx), .mouse_dy_i(mouse_dy), .mouse_rdy_o(mouse_rdy),
    .key_valid_i(key_valid), .key_code_i(key_code), .key_release_i(key_rel),
    .key_rdy_o(key_rdy),
    .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_rdy_o(cmd_rdy),
    .pop_i(pop), .data_o(data), .avail_o(avail)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit mon_en = 0;
  bit force_pop = 0;
  string cur_req = "R1";
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sat(input int v);
    if (v > 127) return 8'h7F;
    if (v < -127) return 8'h81;
    return 8'(v);
  endfunction

  task automatic model_push(input logic [7:0] b);
    if (exp_q.size() < DEPTH) exp_q.push_back(b);
  endtask

  // monitor: pops and compares against the scoreboard
  always @(negedge clk) begin
    if (mon_en && avail) begin
      if (exp_q.size() == 0) begin
        check(0, cur_req, data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(data == e, cur_req, data, e);
      end
      pop = 1'b1;
    end else begin
      pop = force_pop;
    end
  end

  task automatic send_mouse(input logic [2:0] b, input int dx, input int dy);
    @(negedge clk);
    while (!mouse_rdy) @(negedge clk);
    mouse_valid = 1; mouse_btn = b;
    mouse_dx = DELTA_W'(dx); mouse_dy = DELTA_W'(dy);
    @(negedge clk);
    mouse_valid = 0;
    model_push(8'h87 & ~{5'b0, b});
    model_push(sat(dx));
    model_push(sat(-dy));
    model_push(8'h00);
    model_push(8'h00);
  endtask

  task automatic send_key(input logic [6:0] c, input logic rel);
    @(negedge clk);
    while (!key_rdy) @(negedge clk);
    key_valid = 1; key_code = c; key_rel = rel;
    @(negedge clk);
    key_valid = 0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk);
    while (!cmd_rdy) @(negedge clk);
    cmd_valid = 1; cmd_data = c;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic drain(input string req);
    cur_req = req;
    settle();
    mon_en = 1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    mon_en = 0;
    @(negedge clk);
    check(avail == 0, req, avail, 0);
    check(data == 8'h00, req, data, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(avail == 0, "R11", avail, 0);
    check(data == 8'h00, "R11", data, 0);
    check({mouse_rdy, key_rdy, cmd_rdy} == 3'b111, "R11", {mouse_rdy, key_rdy, cmd_rdy}, 7);

    // R2 pop on empty has no effect
    force_pop = 1; @(negedge clk); force_pop = 0; @(negedge clk);
    check(avail == 0, "R2", avail, 0);

    // R3 header encodings
    send_mouse(3'b000, 1, 1);
    send_mouse(3'b101, 0, 0);
    send_mouse(3'b010, 2, -3);
    send_mouse(3'b111, 0, 0);
    drain("R3");

    // R4 saturation
    send_mouse(3'b000, 300, -5);
    send_mouse(3'b000, -200, 200);
    send_mouse(3'b000, -127, -128);
    send_mouse(3'b000, 127, -512);
    drain("R4");

    // R9 press / release
    send_key(7'h2A, 1'b1); model_push(8'hAA);
    send_key(7'h10, 1'b0); model_push(8'h10);
    drain("R9");

    // R10 lock filtering: caps 119 (0x77), num 98 (0x62)
    send_key(7'd119, 0); model_push(8'h77);
    send_key(7'd119, 1);
    send_key(7'd119, 0);
    send_key(7'd119, 1); model_push(8'hF7);
    send_key(7'd98, 0);  model_push(8'h62);
    send_key(7'd98, 1);
    send_key(7'd98, 0);
    send_key(7'd98, 1);  model_push(8'hE2);
    drain("R10");

    // R5 reset command flushes pending bytes
    send_mouse(3'b001, 5, 5);
    settle();
    send_cmd(8'h01);
    exp_q.delete();
    model_push(8'hFF); model_push(8'h04); model_push(8'h7F);
    drain("R5");

    // R6 layout commands
    send_key(7'h05, 0);
    settle();
    send_cmd(8'h07);
    exp_q.delete();
    model_push(8'hFE); model_push(8'h21);
    drain("R6");
    send_cmd(8'h0F);
    model_push(8'hFE); model_push(8'h21);
    drain("R6");

    // R7 LED byte swallowed even if it looks like a command
    send_key(7'h33, 0); model_push(8'h33);
    send_cmd(8'h0E);
    send_cmd(8'h07);
    drain("R7");
    send_cmd(8'h0E);
    send_cmd(8'h01);
    send_cmd(8'h0F);
    model_push(8'hFE); model_push(8'h21);
    drain("R7");

    // R8 unknown command leaves queue unchanged
    send_mouse(3'b100, 9, 9);
    send_cmd(8'h55);
    send_cmd(8'h00);
    drain("R8");

    // R12 simultaneous arrival: cmd, then mouse, then key
    @(negedge clk);
    cmd_valid = 1; cmd_data = 8'h07;
    mouse_valid = 1; mouse_btn = 3'b011; mouse_dx = DELTA_W'(4); mouse_dy = DELTA_W'(-4);
    key_valid = 1; key_code = 7'h21; key_rel = 0;
    @(negedge clk);
    cmd_valid = 0; mouse_valid = 0; key_valid = 0;
    check(key_rdy == 0, "R12", key_rdy, 0);
    check(mouse_rdy == 0, "R12", mouse_rdy, 0);
    exp_q.delete();
    model_push(8'hFE); model_push(8'h21);
    model_push(8'h84); model_push(8'h04); model_push(8'h04);
    model_push(8'h00); model_push(8'h00);
    model_push(8'h21);
    drain("R12");

    // R1 overflow: 52 packets = 260 bytes into a 256-byte queue
    for (int i = 0; i < 52; i++) send_mouse(3'(i), i, -i);
    settle();
    check(avail == 1, "R1", avail, 1);
    drain("R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule